// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the active-low select lines of an SPI master working with one fixed target per transfer. When a start request is accepted it captures a 4-bit target code and a decode-mode flag and drives the select lines from them. In direct mode the lines get a one-cold pattern, and the lowest-order zero bit of the code wins. In decode mode the code goes straight out to an external 4-to-16 decoder.

A release input ends the transfer. All lines go high on the next clock. The block then holds an idle gap of a programmed number of clock cycles, with a floor of six, so that two selects never overlap and a target that is slow to let go of the bus has time to float its output. A ready output tells the shifter when a new transfer may begin. A one-cycle grant pulse confirms an accepted start, and a one-cycle error pulse reports a start that was refused.

Top module: `spi_csel_ctrl`

## Requirements
- R1: After reset `npcs` is 4'b1111, `ready` is 1, and `grant` and `sel_err` are 0.
- R2: With `dec_mode`=0, an accepted code drives `npcs` one-cold at the lowest zero bit of the code: xxx0→1110, xx01→1101, x011→1011, 0111→0111.
- R3: With `dec_mode`=0, a start with code 4'b1111 is refused. `sel_err` pulses for one cycle, `grant` stays 0, `npcs` stays 4'b1111 and `ready` stays 1.
- R4: With `dec_mode`=1, an accepted code is driven onto `npcs` unchanged, including 4'b1111, and no error is raised.
- R5: A start sampled while `ready` is 1 sets `npcs` and a one-cycle `grant` pulse on that same clock edge, and `ready` drops.
- R6: While a select is active, changes to `sel_code` or `dec_mode` and further start requests have no effect on `npcs`.
- R7: A release sampled while a select is active drives `npcs` to 4'b1111 on that clock edge, and `ready` stays 0.
- R8: After a release, `npcs` stays 4'b1111 for exactly max(`gap_cfg`, 6) clock cycles before the next select, given a start that is held.
- R9: `ready` is 0 throughout the gap. A start held through the gap is accepted on the first clock after the gap ends.
- R10: A release sampled while `ready` is 1 has no effect: `ready` stays 1, `npcs` stays high, and the next start is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_code | input | 4 | Target select code |
| dec_mode | input | 1 | 1: pass code straight through, 0: one-cold decode |
| gap_cfg | input | 8 | Inter-select gap in clock cycles (floor 6) |
| start_req | input | 1 | Request to begin a transfer |
| release_req | input | 1 | End of transfer, deselect |
| ready | output | 1 | A start may be accepted |
| grant | output | 1 | One-cycle pulse: start accepted |
| sel_err | output | 1 | One-cycle pulse: start refused (illegal code) |
| npcs | output | 4 | Active-low select lines |

## Verification
The bench walks codes whose upper bits are set as well as clear. A decoder that does not give the lowest zero priority would drive two lines low, or the wrong line, for codes such as 1010 or 1001. It measures the high time after release for gap settings below, at and just above the six-cycle floor, and for a larger setting. An off-by-one in the counter load or the exit test would stretch or shorten every gap by a cycle. It also changes the code while a select is active, and sends a release while idle. A design that does not capture the code, or that starts a gap from idle, shows up as a changed select line or a late grant. The illegal code 1111 is tried in both modes: refused in direct mode, passed through in decode mode.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_GAP  = 2'd2
    } csel_st_e;
endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0] code_i,
    input  logic           pass_i,
    output logic [NCS-1:0] lines_o,
    output logic           illegal_o
);
    logic hit;

    always_comb begin
        lines_o   = '1;
        hit       = 1'b0;
        illegal_o = !pass_i && (&code_i);
        if (pass_i) begin
            lines_o = code_i;
        end else begin
            for (int i = 0; i < NCS; i++) begin
                if (!hit && !code_i[i]) begin
                    lines_o[i] = 1'b0;
                    hit        = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/csel_gap_load.sv
module csel_gap_load #(
    parameter int DLY_W   = 8,
    parameter int MIN_GAP = 6
) (
    input  logic [DLY_W-1:0] cfg_i,
    output logic [DLY_W-1:0] load_o
);
    localparam logic [DLY_W-1:0] FLOOR = DLY_W'(MIN_GAP);

    always_comb begin
        if (cfg_i <= FLOOR) load_o = FLOOR - 1'b1;
        else                load_o = cfg_i - 1'b1;
    end
endmodule

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl #(
    parameter int NCS     = 4,
    parameter int DLY_W   = 8,
    parameter int MIN_GAP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCS-1:0]   sel_code,
    input  logic             dec_mode,
    input  logic [DLY_W-1:0] gap_cfg,
    input  logic             start_req,
    input  logic             release_req,
    output logic             ready,
    output logic             grant,
    output logic             sel_err,
    output logic [NCS-1:0]   npcs
);
    import spi_csel_pkg::*;

    typedef struct packed {
        csel_st_e         st;
        logic [DLY_W-1:0] cnt;
        logic [NCS-1:0]   lines;
        logic             grant;
        logic             err;
    } csel_reg_t;

    csel_reg_t cur_q, nxt_d;

    logic [NCS-1:0]   dec_lines;
    logic             dec_bad;
    logic [DLY_W-1:0] gap_load;
    logic             sel_active;

    csel_decode #(.NCS(NCS)) u_decode (
        .code_i    (sel_code),
        .pass_i    (dec_mode),
        .lines_o   (dec_lines),
        .illegal_o (dec_bad)
    );

    csel_gap_load #(.DLY_W(DLY_W), .MIN_GAP(MIN_GAP)) u_gap (
        .cfg_i  (gap_cfg),
        .load_o (gap_load)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.grant = 1'b0;
        nxt_d.err   = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    if (dec_bad) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        nxt_d.st    = ST_ACT;
                        nxt_d.lines = dec_lines;
                        nxt_d.grant = 1'b1;
                    end
                end
            end
            ST_ACT: begin
                if (release_req) begin
                    nxt_d.st    = ST_GAP;
                    nxt_d.lines = '1;
                    nxt_d.cnt   = gap_load;
                end
            end
            ST_GAP: begin
                if (cur_q.cnt <= DLY_W'(1)) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: begin
                nxt_d.st    = ST_IDLE;
                nxt_d.lines = '1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.lines <= '1;
            cur_q.grant <= 1'b0;
            cur_q.err   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ready      = (cur_q.st == ST_IDLE);
    assign grant      = cur_q.grant;
    assign sel_err    = cur_q.err;
    assign npcs       = cur_q.lines;
    assign sel_active = (cur_q.st == ST_ACT);
endmodule

// File: rtl/spi_csel_chk.sv
module spi_csel_chk #(
    parameter int NCS     = 4,
    parameter int MIN_GAP = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_req,
    input logic           release_req,
    input logic           ready,
    input logic           grant,
    input logic           sel_err,
    input logic [NCS-1:0] npcs,
    input logic           sel_active
);
    logic [7:0] since_rel;
    logic       had_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rel <= '0;
            had_rel   <= 1'b0;
        end else if (release_req && sel_active) begin
            since_rel <= '0;
            had_rel   <= 1'b1;
        end else if (since_rel != 8'hFF) begin
            since_rel <= since_rel + 1'b1;
        end
    end

    // R3: a refused start never selects and never grants
    p_err_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (npcs == '1) && !grant && ready);

    // R5: a grant is only seen on a busy, just-accepted transfer
    p_grant_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !ready && $past(ready) && $past(start_req));

    // R6: the select lines move only at a grant or right after a release
    p_npcs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(npcs) |-> grant || $past(release_req));

    // R7: a release on an active select deselects on the next edge
    p_release_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && sel_active) |=> (npcs == '1) && !ready);

    // R8: never reselect sooner than the floor after a release
    p_min_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && had_rel) |-> (since_rel >= 8'(MIN_GAP)));

    // R9: while ready, nothing is selected
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (npcs == '1) && !sel_active);
endmodule

bind spi_csel_ctrl spi_csel_chk #(.NCS(NCS), .MIN_GAP(MIN_GAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .release_req (release_req),
    .ready       (ready),
    .grant       (grant),
    .sel_err     (sel_err),
    .npcs        (npcs),
    .sel_active  (sel_active)
);

// File: tb/test_spi_csel_ctrl.sv
module test_spi_csel_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_code = '0;
    logic       dec_mode = 1'b0;
    logic [7:0] gap_cfg = '0;
    logic       start_req = 1'b0;
    logic       release_req = 1'b0;
    logic       ready, grant, sel_err;
    logic [3:0] npcs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_csel_ctrl i_spi_csel_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .dec_mode(dec_mode),
        .gap_cfg(gap_cfg), .start_req(start_req), .release_req(release_req),
        .ready(ready), .grant(grant), .sel_err(sel_err), .npcs(npcs)
    );

    // {dec_mode, code, expected npcs, expected err}
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 4'b0000, 4'b1110, 1'b0},
        {1'b0, 4'b1010, 4'b1110, 1'b0},
        {1'b0, 4'b0101, 4'b1101, 1'b0},
        {1'b0, 4'b1001, 4'b1101, 1'b0},
        {1'b0, 4'b0011, 4'b1011, 1'b0},
        {1'b0, 4'b1011, 4'b1011, 1'b0},
        {1'b0, 4'b0111, 4'b0111, 1'b0},
        {1'b0, 4'b1111, 4'b1111, 1'b1},
        {1'b1, 4'b1010, 4'b1010, 1'b0},
        {1'b1, 4'b0110, 4'b0110, 1'b0},
        {1'b1, 4'b1111, 4'b1111, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 300 && !ready; i++) @(negedge clk);
    endtask

    task automatic do_release();
        @(negedge clk) release_req = 1'b1;
        @(negedge clk) release_req = 1'b0;
    endtask

    // Measure high cycles after a release with start held; returns count
    task automatic measure_gap(input logic [7:0] cfg, output int hi);
        gap_cfg  = cfg;
        dec_mode = 1'b0;
        sel_code = 4'b0000;
        wait_ready();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk);
        release_req = 1'b1;
        @(negedge clk) release_req = 1'b0;
        hi = 0;
        for (int i = 0; i < 300 && npcs == 4'b1111; i++) begin
            hi++;
            @(negedge clk);
        end
        start_req = 1'b0;
        do_release();
    endtask

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 npcs", npcs, 4'hF);
        check("R1 ready", ready, 1);
        check("R1 grant/err", {grant, sel_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wait_ready();
            dec_mode = VEC[v][9];
            sel_code = VEC[v][8:5];
            @(negedge clk) start_req = 1'b1;
            @(negedge clk) start_req = 1'b0;
            if (VEC[v][0]) begin
                check("R3 err", sel_err, 1);
                check("R3 npcs/grant/ready", {npcs, grant, ready}, {4'hF, 1'b0, 1'b1});
                @(negedge clk);
                check("R3 err one cycle", sel_err, 0);
            end else begin
                check(VEC[v][9] ? "R4 npcs" : "R2 npcs", npcs, VEC[v][4:1]);
                check("R5 grant/ready/err", {grant, ready, sel_err}, 3'b100);
                @(negedge clk);
                check("R5 grant one cycle", grant, 0);
                do_release();
                check("R7 release", {npcs, ready}, {4'hF, 1'b0});
            end
        end

        // R6: inputs change while active, start retried
        wait_ready();
        dec_mode = 1'b0; sel_code = 4'b0101;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        sel_code = 4'b0000; dec_mode = 1'b1;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        @(negedge clk);
        check("R6 held select", {npcs, grant}, {4'b1101, 1'b0});
        do_release();

        // R8/R9: gap lengths
        measure_gap(8'd0, hi);  check("R8 gap cfg0", hi, 6);
        measure_gap(8'd6, hi);  check("R8 gap cfg6", hi, 6);
        measure_gap(8'd7, hi);  check("R8 gap cfg7", hi, 7);
        measure_gap(8'd20, hi); check("R8 gap cfg20", hi, 20);

        // R9: ready low during gap, start accepted first cycle after
        gap_cfg = 8'd9; dec_mode = 1'b0; sel_code = 4'b0011;
        wait_ready();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        do_release();
        repeat (7) @(negedge clk);
        check("R9 ready low in gap", ready, 0);
        start_req = 1'b1;
        @(negedge clk);
        check("R9 ready at gap end", ready, 1);
        @(negedge clk) start_req = 1'b0;
        check("R9 accept after gap", {grant, npcs}, {1'b1, 4'b1011});
        do_release();

        // R10: release while idle is ignored
        wait_ready();
        do_release();
        check("R10 idle release", {ready, npcs}, {1'b1, 4'hF});
        sel_code = 4'b0111;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        check("R10 immediate accept", {grant, npcs}, {1'b1, 4'b0111});
        do_release();
        wait_ready();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule